// File: doc/BRIEF.md
# Two-Level Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a record of recent branch outcomes (1 for taken, 0 for not taken) in shift-register histories, and uses that pattern to pick one 2-bit saturating counter from an untagged table. The counter's upper bit is the prediction. A build-time parameter picks one of five organisations:
- one global history with a shared table;
- a history per branch with a shared table;
- a history per branch with a table region per branch;
- a global history with a table region per set of address bits;
- a global history XORed with the address.

The fetch stage presents a branch address on the predict port and reads the direction back in the same cycle. When the branch resolves, the pipeline drives the update port with the branch address and its real outcome. On that clock edge the selected counter moves one step and the outcome is shifted into the history. Each counter is a four-state machine with these states:
- SNT: strongly not taken, code 00.
- WNT: weakly not taken, code 01.
- WT: weakly taken, code 10.
- STK: strongly taken, code 11.

A taken update applies the "up" transition, which moves SNT to WNT, WNT to WT and WT to STK, and holds STK. A not-taken update applies the "down" transition, which moves STK to WT, WT to WNT and WNT to SNT, and holds SNT.

Top module: `bp_twolevel`

## Requirements
- R1: Reset places every counter in WNT (code 01), so every address predicts not taken. Reset also clears every history register to zero.
- R2: A taken update moves the selected counter up one state and saturates at STK (11). A not-taken update moves it down one state and saturates at SNT (00).
- R3: `pred_taken_o` is bit 1 of the selected counter, so codes 10 and 11 predict taken. A counter that starts in a strong state reverses its prediction only after two consecutive updates against it.
- R4: Every update shifts its outcome into bit 0 of the history register that belongs to the branch and drops the oldest bit. The global modes use the single register. The per-address modes use the entry selected by PC[5:2], one of 16 untagged entries.
- R5: GAg mode (ORG=0) selects the counter at index {zeros, history}, using the 4-bit global history.
- R6: PAg mode (ORG=1) selects the counter at index {zeros, history}, using the 4-bit history of entry PC[5:2].
- R7: PAp mode (ORG=2) selects the counter at index {PC[7:2], history}, using the history of entry PC[5:2].
- R8: GAs mode (ORG=3) selects the counter at index {zeros, PC[3:2], history}, using the global history.
- R9: gshare mode (ORG=4) selects the counter at index PC[11:2] XOR {zeros, history}, using the global history.
- R10: While `upd_valid_i` is low, no counter and no history changes. The prediction depends only on `pred_pc_i` and on state written at earlier edges, so an update takes effect from the cycle after its edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc_i | input | 32 | Address of the branch being fetched |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | A resolved branch is presented for training |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
All five organisations run side by side on the same stimulus. The main sequence interleaves four branches whose addresses share low bits but differ in PC[5:2], PC[7:6] and PC[11:8]:
- Branches with the same history but different address bits separate GAg and PAg from PAp, GAs and gshare.
- Interleaving several branches separates the global-history modes from the per-address ones.

A single branch that is always taken, then flipped once, then flipped twice, exposes the saturation limits and the two-miss hysteresis. A run of not-taken updates exposes wrap-around at the lower limit. Idle cycles with a changing predict address show that nothing moves without an update.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef enum logic [2:0] {
        ORG_GAG    = 3'd0,
        ORG_PAG    = 3'd1,
        ORG_PAP    = 3'd2,
        ORG_GAS    = 3'd3,
        ORG_GSHARE = 3'd4
    } org_e;

    typedef enum logic [1:0] {
        SNT = 2'b00,
        WNT = 2'b01,
        WT  = 2'b10,
        STK = 2'b11
    } ctr_e;

    function automatic logic org_is_local(org_e o);
        return (o == ORG_PAG) || (o == ORG_PAP);
    endfunction

endpackage

// File: rtl/bp_hist.sv
module bp_hist
    import bp_pkg::*;
#(
    parameter org_e ORG       = ORG_GSHARE,
    parameter int   HIST_BITS = 4,
    parameter int   BHT_IDX   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BHT_IDX-1:0]   rd_sel_i,
    input  logic [BHT_IDX-1:0]   upd_sel_i,
    input  logic                 upd_valid_i,
    input  logic                 upd_taken_i,
    output logic [HIST_BITS-1:0] rd_hist_o,
    output logic [HIST_BITS-1:0] upd_hist_o
);
    localparam int BHT_DEPTH = 1 << BHT_IDX;

    generate
        if (org_is_local(ORG)) begin : g_local
            logic [HIST_BITS-1:0] bhr_q [BHT_DEPTH];

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < BHT_DEPTH; i++) bhr_q[i] <= '0;
                end else if (upd_valid_i) begin
                    bhr_q[upd_sel_i] <= {bhr_q[upd_sel_i][HIST_BITS-2:0], upd_taken_i};
                end
            end

            assign rd_hist_o  = bhr_q[rd_sel_i];
            assign upd_hist_o = bhr_q[upd_sel_i];

            // R4: the branch's own history takes the outcome in bit 0
            p_local_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid_i |=> bhr_q[$past(upd_sel_i)][0] == $past(upd_taken_i));
        end else begin : g_global
            logic [HIST_BITS-1:0] ghr_q;
            logic                 unused_sel;

            assign unused_sel = ^{rd_sel_i, upd_sel_i};

            always_ff @(posedge clk) begin
                if (!rst_n)           ghr_q <= '0;
                else if (upd_valid_i) ghr_q <= {ghr_q[HIST_BITS-2:0], upd_taken_i};
            end

            assign rd_hist_o  = ghr_q;
            assign upd_hist_o = ghr_q;

            // R4: outcome enters bit 0, older bits move up
            p_global_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
                upd_valid_i |=> (ghr_q[0] == $past(upd_taken_i)) &&
                                (ghr_q[HIST_BITS-1:1] == $past(ghr_q[HIST_BITS-2:0])));
            // R10: no update, no history movement
            p_global_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !upd_valid_i |=> $stable(ghr_q));
        end
    endgenerate

endmodule

// File: rtl/bp_index.sv
module bp_index
    import bp_pkg::*;
#(
    parameter org_e ORG       = ORG_GSHARE,
    parameter int   HIST_BITS = 4,
    parameter int   IDX_BITS  = 10,
    parameter int   SET_BITS  = 2
) (
    input  logic [IDX_BITS-1:0]  pc_i,
    input  logic [HIST_BITS-1:0] hist_i,
    output logic [IDX_BITS-1:0]  idx_o
);
    localparam int ADDR_BITS = IDX_BITS - HIST_BITS;

    generate
        if (ORG == ORG_GAG || ORG == ORG_PAG) begin : g_hist_only
            logic unused_pc;
            assign unused_pc = ^pc_i;
            assign idx_o     = IDX_BITS'(hist_i);
        end else if (ORG == ORG_PAP) begin : g_pap
            logic unused_pc;
            assign unused_pc = ^pc_i[IDX_BITS-1:ADDR_BITS];
            assign idx_o     = {pc_i[ADDR_BITS-1:0], hist_i};
        end else if (ORG == ORG_GAS) begin : g_gas
            logic unused_pc;
            assign unused_pc = ^pc_i[IDX_BITS-1:SET_BITS];
            assign idx_o     = IDX_BITS'({pc_i[SET_BITS-1:0], hist_i});
        end else begin : g_gshare
            assign idx_o = pc_i ^ IDX_BITS'(hist_i);
        end
    endgenerate

endmodule

// File: rtl/bp_pht.sv
module bp_pht
    import bp_pkg::*;
#(
    parameter int IDX_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] rd_idx_i,
    output ctr_e                rd_ctr_o,
    input  logic                wr_en_i,
    input  logic [IDX_BITS-1:0] wr_idx_i,
    input  logic                wr_taken_i
);
    localparam int DEPTH = 1 << IDX_BITS;

    ctr_e tbl_q [DEPTH];
    ctr_e cur_st;
    ctr_e nxt_st;

    assign cur_st = tbl_q[wr_idx_i];

    always_comb begin
        nxt_st = cur_st;
        unique case (cur_st)
            SNT: nxt_st = wr_taken_i ? WNT : SNT;
            WNT: nxt_st = wr_taken_i ? WT  : SNT;
            WT:  nxt_st = wr_taken_i ? STK : WNT;
            STK: nxt_st = wr_taken_i ? STK : WT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= WNT;
        end else if (wr_en_i) begin
            tbl_q[wr_idx_i] <= nxt_st;
        end
    end

    assign rd_ctr_o = tbl_q[rd_idx_i];

    // R2: upper saturation
    p_sat_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_taken_i && cur_st == STK) |=> tbl_q[$past(wr_idx_i)] == STK);
    // R2: lower saturation
    p_sat_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_taken_i && cur_st == SNT) |=> tbl_q[$past(wr_idx_i)] == SNT);
    // R3: one miss from a strong state keeps the direction
    p_hyst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_taken_i && cur_st == STK) |=> tbl_q[$past(wr_idx_i)] == WT);
    // R2: a single step in the taken direction
    p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_taken_i && cur_st == WNT) |=> tbl_q[$past(wr_idx_i)] == WT);

endmodule

// File: rtl/bp_twolevel.sv
module bp_twolevel
    import bp_pkg::*;
#(
    parameter org_e ORG         = ORG_GSHARE,
    parameter int   PC_W        = 32,
    parameter int   HIST_BITS   = 4,
    parameter int   IDX_BITS    = 10,
    parameter int   SET_BITS    = 2,
    parameter int   BHT_ENTRIES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc_i,
    output logic            pred_taken_o,
    input  logic            upd_valid_i,
    input  logic [PC_W-1:0] upd_pc_i,
    input  logic            upd_taken_i
);
    localparam int BHT_IDX = $clog2(BHT_ENTRIES);

    logic [HIST_BITS-1:0] rd_hist;
    logic [HIST_BITS-1:0] upd_hist;
    logic [IDX_BITS-1:0]  rd_idx;
    logic [IDX_BITS-1:0]  wr_idx;
    ctr_e                 rd_ctr;
    logic                 unused_pc_bits;

    assign unused_pc_bits = ^{pred_pc_i[PC_W-1:IDX_BITS+2], pred_pc_i[1:0],
                              upd_pc_i[PC_W-1:IDX_BITS+2], upd_pc_i[1:0]};

    bp_hist #(.ORG(ORG), .HIST_BITS(HIST_BITS), .BHT_IDX(BHT_IDX)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_sel_i   (pred_pc_i[2 +: BHT_IDX]),
        .upd_sel_i  (upd_pc_i[2 +: BHT_IDX]),
        .upd_valid_i(upd_valid_i),
        .upd_taken_i(upd_taken_i),
        .rd_hist_o  (rd_hist),
        .upd_hist_o (upd_hist)
    );

    bp_index #(.ORG(ORG), .HIST_BITS(HIST_BITS), .IDX_BITS(IDX_BITS), .SET_BITS(SET_BITS)) u_rd_index (
        .pc_i  (pred_pc_i[2 +: IDX_BITS]),
        .hist_i(rd_hist),
        .idx_o (rd_idx)
    );

    bp_index #(.ORG(ORG), .HIST_BITS(HIST_BITS), .IDX_BITS(IDX_BITS), .SET_BITS(SET_BITS)) u_wr_index (
        .pc_i  (upd_pc_i[2 +: IDX_BITS]),
        .hist_i(upd_hist),
        .idx_o (wr_idx)
    );

    bp_pht #(.IDX_BITS(IDX_BITS)) u_pht (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (rd_idx),
        .rd_ctr_o  (rd_ctr),
        .wr_en_i   (upd_valid_i),
        .wr_idx_i  (wr_idx),
        .wr_taken_i(upd_taken_i)
    );

    assign pred_taken_o = rd_ctr[1];

    // R3: prediction tracks the upper counter bit
    p_pred_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken_o == (rd_ctr == WT || rd_ctr == STK));

endmodule

// File: tb/test_bp_twolevel.sv
module test_bp_twolevel;
    import bp_pkg::*;

    localparam int NORG = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [NORG-1:0] pred;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    for (genvar g = 0; g < NORG; g++) begin : g_dut
        bp_twolevel #(.ORG(org_e'(g))) i_bp_twolevel (
            .clk         (clk),
            .rst_n       (rst_n),
            .pred_pc_i   (pred_pc),
            .pred_taken_o(pred[g]),
            .upd_valid_i (upd_valid),
            .upd_pc_i    (upd_pc),
            .upd_taken_i (upd_taken)
        );
    end

    // reference state built from the requirements
    logic [1:0] m_ctr [NORG][1024];
    logic [3:0] m_gh  [NORG];
    logic [3:0] m_lh  [NORG][16];
    string org_tag [NORG] = '{"R5", "R6", "R7", "R8", "R9"};

    function automatic logic [3:0] m_hist(int o, logic [31:0] pc);
        return (o == 1 || o == 2) ? m_lh[o][pc[5:2]] : m_gh[o];
    endfunction

    function automatic logic [9:0] m_idx(int o, logic [31:0] pc);
        logic [3:0] h = m_hist(o, pc);
        case (o)
            0, 1:    return {6'd0, h};
            2:       return {pc[7:2], h};
            3:       return {4'd0, pc[3:2], h};
            default: return pc[11:2] ^ {6'd0, h};
        endcase
    endfunction

    task automatic m_reset();
        for (int o = 0; o < NORG; o++) begin
            m_gh[o] = '0;
            for (int i = 0; i < 16; i++) m_lh[o][i] = '0;
            for (int i = 0; i < 1024; i++) m_ctr[o][i] = 2'b01;
        end
    endtask

    task automatic m_update(logic [31:0] pc, bit tk);
        for (int o = 0; o < NORG; o++) begin
            logic [9:0] ix = m_idx(o, pc);
            if (tk && m_ctr[o][ix] != 2'b11) m_ctr[o][ix] = m_ctr[o][ix] + 2'd1;
            if (!tk && m_ctr[o][ix] != 2'b00) m_ctr[o][ix] = m_ctr[o][ix] - 2'd1;
            if (o == 1 || o == 2) m_lh[o][pc[5:2]] = {m_lh[o][pc[5:2]][2:0], tk};
            else m_gh[o] = {m_gh[o][2:0], tk};
        end
    endtask

    task automatic check_all(logic [31:0] pc, string tag);
        for (int o = 0; o < NORG; o++) begin
            logic exp = m_ctr[o][m_idx(o, pc)][1];
            n_chk++;
            if (pred[o] !== exp) begin
                n_err++;
                $display("FAIL %s/%s org=%0d pc=%h actual=%0b expected=%0b",
                         tag, org_tag[o], o, pc, pred[o], exp);
            end
        end
    endtask

    task automatic step(logic [31:0] pc, bit tk, string tag);
        @(negedge clk);
        upd_valid = 1'b0;
        pred_pc = pc;
        #1;
        check_all(pc, tag);
        upd_valid = 1'b1;
        upd_pc = pc;
        upd_taken = tk;
        @(posedge clk);
        m_update(pc, tk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        m_reset();
        rst_n = 1'b1;
    endtask

    // {pc, outcome}
    localparam logic [32:0] VEC [16] = '{
        {32'h0000_0100, 1'b1}, {32'h0000_0204, 1'b0}, {32'h0000_0100, 1'b1}, {32'h0000_0204, 1'b0},
        {32'h0000_0100, 1'b0}, {32'h0000_03F8, 1'b1}, {32'h0000_0100, 1'b1}, {32'h0000_0040, 1'b1},
        {32'h0000_0204, 1'b1}, {32'h0000_03F8, 1'b0}, {32'h0000_0100, 1'b1}, {32'h0000_0204, 1'b0},
        {32'h0000_0040, 1'b0}, {32'h0000_0100, 1'b1}, {32'h0000_03F8, 1'b1}, {32'h0000_0204, 1'b0}
    };

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: every address predicts not taken after reset
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pred_pc = 32'h40 * i + 32'h4;
            #1;
            check_all(pred_pc, "R1");
            n_chk++;
            if (pred !== '0) begin
                n_err++;
                $display("FAIL R1 actual=%b expected=00000", pred);
            end
        end

        // R4..R9: interleaved branches, several passes to train
        for (int pass = 0; pass < 4; pass++)
            for (int v = 0; v < 16; v++)
                step(VEC[v][32:1], VEC[v][0], "R4");

        // R10: idle cycles with a moving predict address
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            upd_valid = 1'b0;
            pred_pc = VEC[i][32:1];
            @(posedge clk);
            @(negedge clk);
            #1;
            check_all(pred_pc, "R10");
        end

        // R2/R3: saturation high and two-miss hysteresis on one branch
        do_reset();
        for (int i = 0; i < 10; i++) step(32'h0000_0100, 1'b1, "R2");
        step(32'h0000_0100, 1'b0, "R3");
        for (int i = 0; i < 4; i++) step(32'h0000_0100, 1'b1, "R3");
        step(32'h0000_0100, 1'b0, "R3");
        step(32'h0000_0100, 1'b0, "R3");
        for (int i = 0; i < 4; i++) step(32'h0000_0100, 1'b1, "R3");

        // R2: saturation low
        do_reset();
        for (int i = 0; i < 10; i++) step(32'h0000_0204, 1'b0, "R2");
        step(32'h0000_0204, 1'b1, "R2");
        for (int i = 0; i < 5; i++) step(32'h0000_0204, 1'b0, "R2");

        @(negedge clk);
        upd_valid = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule